// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges six reset requests into one system reset that is synchronous to the system clock. The six requests are a supply-low flag, a watchdog timeout, a missing-clock detector, a comparator level-detect, a software strobe and an active-low external reset pad. Any request that is enabled starts or extends a reset pulse. The pulse is at least `MIN_PULSE` cycles long, and its release is aligned to the clock. While a reset caused from inside the block is active, the block pulls the bidirectional reset pad low, so other devices on the board see the same reset.

Software uses a small control word. The word holds enables for the watchdog, the missing-clock detector and the comparator, a one-shot software-reset strobe and a sticky watchdog lock. Software cannot mask two requests: the supply-low flag, which is gated only by a dedicated monitor-enable pin, and the external pad. A read-only cause code reports which request started or last extended the most recent reset. Every reset returns the enables to zero. Only the power-on input clears the lock.

Top module: `rst_funnel`

## Requirements
- R1: An enabled request, seen after its 2-flop input synchroniser, raises `sys_rst` at the next clock edge. Requests from several sources combine by OR.
- R2: `sys_rst` stays high for at least 16 cycles. A request that lasts a single cycle gives exactly 16 cycles. A request held longer keeps `sys_rst` high until 16 cycles after its last cycle.
- R3: `rst_pin_oe` is high only during a reset that an internal request caused. A synchronised low on `rst_pin_n_in` causes a reset with cause code 2 and does not drive the pad. A low on the pad within 3 cycles after the block's own drive is ignored.
- R4: `supply_low` causes a reset (code 1) only while `mon_en` is high. No control bit can mask it.
- R5: The control word fields are bit0 watchdog enable, bit1 missing-clock enable, bit2 comparator enable, bit3 lock and bit4 software strobe. Any reset clears bits 0 to 2. A write that arrives while reset is active or being requested is ignored.
- R6: Writing 1 to bit3 sets the lock. With the lock set, the watchdog runs whatever bit0 holds, and `ctl_q[0]` reads 1. The lock survives every reset except `por`.
- R7: When the watchdog is enabled, it counts clock cycles and `wdt_kick` clears the count. If `WDT_LIMIT` edges pass after a kick with no further kick, a reset with code 3 follows.
- R8: When the missing-clock detector is enabled and the synchronised `mclk_in` shows no edge for more than `mcd_limit` cycles, a reset with code 4 follows. A monitored clock that toggles faster than that causes no reset.
- R9: A write with bit4 set gives one reset of exactly 16 cycles with code 6, and `ctl_q[4]` always reads 0.
- R10: `rst_cause` is overwritten at every request cycle. When several requests arrive together, the code follows the order supply(1) > pad(2) > watchdog(3) > missing clock(4) > comparator(5) > software(6). Power-on gives code 0.
- R11: While `por` is high, `sys_rst` is high. It stays high for 16 cycles after `por` falls, and during that time `ctl_q` reads 0 and `rst_cause` reads 0.
- R12: `cmp_low` causes a reset (code 5) only while bit2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on reset, active high, synchronous |
| mon_en | input | 1 | Supply-monitor enable pin |
| supply_low | input | 1 | Supply-low flag (asynchronous) |
| cmp_low | input | 1 | Comparator level-detect (asynchronous) |
| rst_pin_n_in | input | 1 | Sensed level of the reset pad, active low |
| rst_pin_oe | output | 1 | Drive the reset pad low |
| mclk_in | input | 1 | Monitored clock (asynchronous) |
| mcd_limit | input | MCD_W | Missing-clock cycle limit |
| wdt_kick | input | 1 | Watchdog restart strobe |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word write data |
| ctl_q | output | 5 | Control word readback |
| rst_cause | output | 3 | Cause code of the last reset |
| sys_rst | output | 1 | Synchronised system reset |

## Verification
A stuck or wrong stretch counter appears on `sys_rst` as a pulse width other than 16 cycles. This shows on the first software reset, within about 20 cycles. A bad priority encoder or a bad status register gives a wrong `rst_cause` at the end of the pulse. A watchdog counter that is off by one moves the rising edge of `sys_rst` by one cycle against the point 40 cycles after the kick. A broken pad guard or output-enable term shows up as a second, unrequested reset directly after a pulse the block caused itself. A lock that is lost shows in `ctl_q` right after the next reset.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    localparam int CTL_W  = 5;
    localparam int NSRC   = 6;

    // control word bit positions
    localparam int B_WDT  = 0;
    localparam int B_MCD  = 1;
    localparam int B_CMP  = 2;
    localparam int B_LOCK = 3;
    localparam int B_SW   = 4;

    // request vector index = priority order (lower index wins)
    localparam int S_SUP  = 0;
    localparam int S_PIN  = 1;
    localparam int S_WDT  = 2;
    localparam int S_MCD  = 3;
    localparam int S_CMP  = 4;
    localparam int S_SW   = 5;

    typedef enum logic [2:0] {
        CAUSE_POR = 3'd0,
        CAUSE_SUP = 3'd1,
        CAUSE_PIN = 3'd2,
        CAUSE_WDT = 3'd3,
        CAUSE_MCD = 3'd4,
        CAUSE_CMP = 3'd5,
        CAUSE_SW  = 3'd6
    } cause_e;

    typedef struct packed {
        logic lock;
        logic cmp_en;
        logic mcd_en;
        logic wdt_en;
    } ctl_t;

    function automatic cause_e pick_cause(input logic [NSRC-1:0] req);
        cause_e c;
        c = CAUSE_POR;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) c = cause_e'(3'(i + 1));
        end
        return c;
    endfunction

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
    parameter int         W       = 1,
    parameter logic [0:0] RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= {W{RST_VAL}};
            q  <= {W{RST_VAL}};
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/rstc_wdt.sv
module rstc_wdt #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic clr,
    input  logic en,
    input  logic kick,
    output logic timeout
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr || !en || kick) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    assign timeout = en && (cnt == LAST);
endmodule

// File: rtl/rstc_mcd.sv
module rstc_mcd #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          en,
    input  logic          mclk_s,
    input  logic [CW-1:0] limit,
    output logic          timeout
);
    logic          mclk_d;
    logic [CW-1:0] cnt;
    logic          edge_seen;

    assign edge_seen = mclk_s ^ mclk_d;

    always_ff @(posedge clk) begin
        mclk_d <= mclk_s;
        if (clr || !en || edge_seen) cnt <= '0;
        else if (cnt != {CW{1'b1}})  cnt <= cnt + 1'b1;
    end

    assign timeout = en && !edge_seen && (cnt >= limit);
endmodule

// File: rtl/rst_funnel.sv
module rst_funnel
    import rstc_pkg::*;
#(
    parameter int MIN_PULSE = 16,
    parameter int WDT_LIMIT = 1024,
    parameter int MCD_W     = 8,
    parameter int GUARD     = 3
) (
    input  logic             clk,
    input  logic             por,
    input  logic             mon_en,
    input  logic             supply_low,
    input  logic             cmp_low,
    input  logic             rst_pin_n_in,
    output logic             rst_pin_oe,
    input  logic             mclk_in,
    input  logic [MCD_W-1:0] mcd_limit,
    input  logic             wdt_kick,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_q,
    output logic [2:0]       rst_cause,
    output logic             sys_rst
);
    localparam int PW = $clog2(MIN_PULSE + 1);
    localparam logic [PW-1:0] PLOAD = PW'(MIN_PULSE - 1);

    // synchronised asynchronous inputs
    logic sup_s, cmp_s, mclk_s, pin_s;

    rstc_sync #(.W(3), .RST_VAL(1'b0)) u_sync_lo (
        .clk(clk), .rst(por),
        .d({supply_low, cmp_low, mclk_in}),
        .q({sup_s, cmp_s, mclk_s})
    );

    rstc_sync #(.W(1), .RST_VAL(1'b1)) u_sync_pin (
        .clk(clk), .rst(por), .d(rst_pin_n_in), .q(pin_s)
    );

    // state
    ctl_t             ctl;
    logic             sw_pulse;
    logic             active;
    logic [PW-1:0]    cnt;
    logic             int_drv;
    logic [GUARD-1:0] guard;
    cause_e           cause_q;

    logic             wdt_to, mcd_to;
    logic [NSRC-1:0]  req_v;
    logic             req, int_req, nxt_active, busy;

    rstc_wdt #(.LIMIT(WDT_LIMIT)) u_wdt (
        .clk(clk), .clr(active), .en(ctl.wdt_en | ctl.lock),
        .kick(wdt_kick), .timeout(wdt_to)
    );

    rstc_mcd #(.CW(MCD_W)) u_mcd (
        .clk(clk), .clr(active), .en(ctl.mcd_en), .mclk_s(mclk_s),
        .limit(mcd_limit), .timeout(mcd_to)
    );

    always_comb begin
        req_v        = '0;
        req_v[S_SUP] = mon_en & sup_s;
        req_v[S_PIN] = ~pin_s & ~rst_pin_oe & ~(|guard);
        req_v[S_WDT] = wdt_to;
        req_v[S_MCD] = mcd_to;
        req_v[S_CMP] = ctl.cmp_en & cmp_s;
        req_v[S_SW]  = sw_pulse;
        req          = |req_v;
        int_req      = req & ~req_v[S_PIN] | (|(req_v & ~(NSRC'(1) << S_PIN)));
        nxt_active   = req | (active & (cnt != '0));
        busy         = req | active;
    end

    // pulse stretcher, pad drive and cause capture
    always_ff @(posedge clk) begin
        if (por) begin
            active  <= 1'b1;
            cnt     <= PLOAD;
            int_drv <= 1'b1;
            guard   <= {GUARD{1'b1}};
            cause_q <= CAUSE_POR;
        end else begin
            active  <= nxt_active;
            int_drv <= int_req | (int_drv & nxt_active);
            guard   <= {guard[GUARD-2:0], rst_pin_oe};
            if (req) begin
                cnt     <= PLOAD;
                cause_q <= pick_cause(req_v);
            end else if (cnt != '0) begin
                cnt     <= cnt - 1'b1;
            end
        end
    end

    // control word
    always_ff @(posedge clk) begin
        if (por) begin
            ctl      <= '0;
            sw_pulse <= 1'b0;
        end else begin
            sw_pulse <= ctl_we & ~busy & ctl_wdata[B_SW];
            if (busy) begin
                ctl.wdt_en <= 1'b0;
                ctl.mcd_en <= 1'b0;
                ctl.cmp_en <= 1'b0;
            end else if (ctl_we) begin
                ctl.wdt_en <= ctl_wdata[B_WDT];
                ctl.mcd_en <= ctl_wdata[B_MCD];
                ctl.cmp_en <= ctl_wdata[B_CMP];
                ctl.lock   <= ctl.lock | ctl_wdata[B_LOCK];
            end
        end
    end

    assign sys_rst    = active;
    assign rst_pin_oe = active & int_drv;
    assign rst_cause  = cause_q;
    assign ctl_q      = {1'b0, ctl.lock, ctl.cmp_en, ctl.mcd_en, ctl.wdt_en | ctl.lock};

    // ---------------- assertions ----------------
    logic [PW-1:0] chk_len;
    always_ff @(posedge clk) begin
        if (por)                             chk_len <= '0;
        else if (!active)                    chk_len <= '0;
        else if (chk_len != PW'(MIN_PULSE))  chk_len <= chk_len + 1'b1;
    end

    assert_min_pulse_R2: assert property (@(posedge clk) disable iff (por)
        $fell(sys_rst) |-> chk_len == PW'(MIN_PULSE));

    assert_pad_only_in_reset_R3: assert property (@(posedge clk) disable iff (por)
        rst_pin_oe |-> sys_rst);

    assert_supply_resets_R4: assert property (@(posedge clk) disable iff (por)
        (mon_en && sup_s) |=> sys_rst);

    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (por)
        ctl.lock |=> ctl.lock);

    assert_wdt_timeout_R7: assert property (@(posedge clk) disable iff (por)
        wdt_to |=> (sys_rst && rst_pin_oe));

    assert_mcd_timeout_R8: assert property (@(posedge clk) disable iff (por)
        mcd_to |=> sys_rst);

    assert_sw_strobe_R9: assert property (@(posedge clk) disable iff (por)
        sw_pulse |=> (sys_rst && !sw_pulse));

    assert_cause_legal_R10: assert property (@(posedge clk) disable iff (por)
        rst_cause <= 3'd6);
endmodule

// File: tb/test_rst_funnel.sv
module test_rst_funnel;
    import rstc_pkg::*;

    localparam int WL = 40;

    logic       clk = 1'b0;
    logic       por, mon_en, supply_low, cmp_low, mclk_in, wdt_kick, ctl_we;
    logic [7:0] mcd_limit;
    logic [4:0] ctl_wdata;
    logic [4:0] ctl_q;
    logic [2:0] rst_cause;
    logic       sys_rst, rst_pin_oe, pin_low;
    wire        rst_pin_n_in = ~(pin_low | rst_pin_oe);

    int checks = 0, errors = 0;
    bit kick_on = 0, mclk_run = 0, done = 0;

    typedef struct { logic [2:0] cause; int width; string tag; } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    rst_funnel #(.MIN_PULSE(16), .WDT_LIMIT(WL), .MCD_W(8), .GUARD(3)) i_rst_funnel (
        .clk(clk), .por(por), .mon_en(mon_en), .supply_low(supply_low),
        .cmp_low(cmp_low), .rst_pin_n_in(rst_pin_n_in), .rst_pin_oe(rst_pin_oe),
        .mclk_in(mclk_in), .mcd_limit(mcd_limit), .wdt_kick(wdt_kick),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
        .rst_cause(rst_cause), .sys_rst(sys_rst)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_reset(input logic [2:0] c, input int w, input string tag);
        exp_t e;
        e.cause = c; e.width = w; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic write_ctl(input logic [4:0] d);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
        @(negedge clk); ctl_we = 1'b0; ctl_wdata = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: measure each pulse and compare with the queue head
    initial begin
        int w;
        exp_t e;
        w = 0;
        forever begin
            @(negedge clk);
            if (sys_rst === 1'b1) w++;
            else if (w > 0) begin
                if (exp_q.size() == 0) begin
                    check(0, "R1 unexpected reset, cause", int'(rst_cause), -1);
                end else begin
                    e = exp_q.pop_front();
                    check(rst_cause == e.cause, {e.tag, " cause"}, int'(rst_cause), int'(e.cause));
                    if (e.width != 0)
                        check(w == e.width, {e.tag, " R2 width"}, w, e.width);
                    else
                        check(w >= 16, {e.tag, " R2 min width"}, w, 16);
                end
                w = 0;
            end
        end
    end

    // background watchdog kicker
    initial begin
        int k;
        k = 0;
        forever begin
            @(negedge clk);
            if (kick_on) begin
                k++;
                wdt_kick = (k % 10 == 0);
            end
        end
    end

    // monitored clock
    initial begin
        mclk_in = 1'b0;
        forever begin
            idle(4);
            if (mclk_run) mclk_in = ~mclk_in;
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(0, "watchdog timeout", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        por = 1'b1; mon_en = 1'b0; supply_low = 1'b0; cmp_low = 1'b0;
        wdt_kick = 1'b0; ctl_we = 1'b0; ctl_wdata = '0; pin_low = 1'b0;
        mcd_limit = 8'd12;
        expect_reset(CAUSE_POR, 0, "R11 por");
        idle(5);
        por = 1'b0;
        @(negedge clk);
        check(sys_rst == 1'b1, "R11 reset held after por", int'(sys_rst), 1);
        check(ctl_q == 5'b0, "R11 ctl cleared", int'(ctl_q), 0);
        check(rst_cause == 3'd0, "R11 cause por", int'(rst_cause), 0);
        idle(20);
        check(sys_rst == 1'b0, "R11 released", int'(sys_rst), 0);

        // R9 software strobe, R5 write during reset ignored
        expect_reset(CAUSE_SW, 16, "R9 sw");
        write_ctl(5'b10000);
        idle(3);
        check(rst_pin_oe == 1'b1, "R3 pad driven for internal reset", int'(rst_pin_oe), 1);
        write_ctl(5'b00111);
        idle(20);
        check(ctl_q == 5'b0, "R5 write during reset ignored", int'(ctl_q), 0);
        check(ctl_q[4] == 1'b0, "R9 strobe reads 0", int'(ctl_q[4]), 0);

        // R4 supply gated by mon_en
        supply_low = 1'b1;
        idle(20);
        check(sys_rst == 1'b0, "R4 supply ignored without mon_en", int'(sys_rst), 0);
        expect_reset(CAUSE_SUP, 0, "R4 supply");
        mon_en = 1'b1;
        idle(6);
        supply_low = 1'b0;
        idle(30);
        mon_en = 1'b0;

        // R3 external pad
        expect_reset(CAUSE_PIN, 0, "R3 pad");
        pin_low = 1'b1;
        idle(4);
        check(sys_rst == 1'b1 && rst_pin_oe == 1'b0, "R3 external reset not driven",
              int'({sys_rst, rst_pin_oe}), 2);
        pin_low = 1'b0;
        idle(30);

        // R12 comparator masked, then R10 priority comparator over software
        cmp_low = 1'b1;
        idle(20);
        check(sys_rst == 1'b0, "R12 comparator masked", int'(sys_rst), 0);
        expect_reset(CAUSE_CMP, 16, "R10 R12 cmp over sw");
        write_ctl(5'b10100);
        idle(25);
        cmp_low = 1'b0;
        check(ctl_q == 5'b0, "R5 enables cleared by reset", int'(ctl_q), 0);

        // R7 watchdog
        kick_on = 1;
        write_ctl(5'b00001);
        idle(150);
        check(sys_rst == 1'b0, "R7 kicked watchdog quiet", int'(sys_rst), 0);
        kick_on = 0;
        @(negedge clk); wdt_kick = 1'b1;
        expect_reset(CAUSE_WDT, 16, "R7 wdt");
        @(negedge clk); wdt_kick = 1'b0;
        idle(WL - 2);
        check(sys_rst == 1'b0, "R7 no reset before limit", int'(sys_rst), 0);
        idle(2);
        check(sys_rst == 1'b1, "R7 reset at limit", int'(sys_rst), 1);
        idle(25);

        // R6 lock
        kick_on = 1;
        write_ctl(5'b01001);
        write_ctl(5'b00000);
        check(ctl_q == 5'b01001, "R6 lock forces watchdog", int'(ctl_q), 9);
        kick_on = 0;
        wdt_kick = 1'b0;
        expect_reset(CAUSE_WDT, 16, "R6 locked wdt");
        idle(WL + 10);
        kick_on = 1;
        idle(20);
        check(ctl_q == 5'b01001, "R6 lock survives reset", int'(ctl_q), 9);
        expect_reset(CAUSE_POR, 0, "R6 por clears lock");
        por = 1'b1;
        idle(3);
        por = 1'b0;
        kick_on = 0;
        wdt_kick = 1'b0;
        @(negedge clk);
        check(ctl_q == 5'b0, "R6 lock cleared by por", int'(ctl_q), 0);
        idle(25);

        // R8 missing clock
        mclk_run = 1;
        write_ctl(5'b00010);
        idle(100);
        check(sys_rst == 1'b0, "R8 running clock quiet", int'(sys_rst), 0);
        expect_reset(CAUSE_MCD, 16, "R8 mcd");
        mclk_run = 0;
        idle(50);

        check(exp_q.size() == 0, "R1 all expected resets seen", exp_q.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule